// File: doc/BRIEF.md
# Serial Coefficient Write Port

This block accepts coefficient writes from a host over three asynchronous wires: a shift clock, a serial data line and a load strobe. On each rising edge of the shift clock one bit is taken from the data line. A complete transfer is sixteen bits: an 8-bit register address comes first, then 8 data bits, and each field is sent most-significant bit first. A separate rising edge on the load strobe commits the transfer. The data goes into an internal bank of 256 byte-wide registers, and a one-cycle update pulse tells downstream logic to adopt the new values.

All three wires are brought into the system clock domain through two-stage synchronisers, and their edges are detected there. The shift clock must stay below 20 MHz, which is far slower than the system clock.

A strobe that arrives after any bit count other than exactly sixteen discards the transfer. Every strobe resets the bit count. Downstream logic reads the bank through a registered read port. Coefficients wider than a byte are stored as two independent neighbouring addresses, and each one is written by its own transfer.

Top module: `coef_serial_port`

## Requirements
- R1: After reset, every register reads as zero and `update_o` is low.
- R2: Of the sixteen bits in a transfer, the first eight are the address and the last eight are the data. Each field is shifted most-significant bit first, sampled on the rising edge of `ser_clk_i`.
- R3: A rising edge of `ser_ld_i` that follows exactly sixteen shift-clock rising edges writes the data byte into the addressed register.
- R4: A strobe that follows fewer than sixteen shifted bits, including none, writes nothing and raises no update pulse.
- R5: A strobe that follows more than sixteen shifted bits writes nothing and raises no update pulse.
- R6: Every strobe clears the bit count, so a correct transfer that follows a discarded one is committed normally.
- R7: Each committed write produces exactly one `update_o` pulse, one system clock wide. `update_o` is never high at any other time.
- R8: `rd_data_o` shows the register selected by `rd_addr_i` one system clock later. A register that has never been written reads as zero.
- R9: A write changes only the addressed register. A second write to the same address replaces the earlier value.
- R10: Shifting bits without a strobe changes no register and raises no pulse. The shifted word is held until a strobe arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial shift clock; data is sampled on its rising edge |
| ser_dat_i | input | 1 | Asynchronous serial data, most-significant bit first |
| ser_ld_i | input | 1 | Asynchronous load strobe; its rising edge commits the transfer |
| rd_addr_i | input | 8 | Register select for the downstream read port |
| rd_data_o | output | 8 | Contents of the selected register, one clock after the address |
| update_o | output | 1 | One-cycle pulse after each committed write |

## Verification
The assertions assume that every level on the serial wires stays put for at least three system clocks, so that each pin edge becomes exactly one synchronised edge. They also assume the data line is settled before the shift clock rises. The stimulus holds data for three clocks before each shift-clock rise, keeps the clock high for four clocks and low for at least three, and keeps the strobe high for four clocks. The count property checks every committed write against an independent count of synchronised shift edges taken since the last strobe.

// File: rtl/coef_serial_pkg.sv
`timescale 1ns/1ps
package coef_serial_pkg;
  localparam int unsigned ADDR_BITS   = 8;
  localparam int unsigned DATA_BITS   = 8;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/csp_sync.sv
`timescale 1ns/1ps
// Per-bit multi-flop synchroniser; one chain per input wire.
module csp_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/csp_deframe.sv
`timescale 1ns/1ps
// Edge detection, shifting, bit counting and frame check on strobe.
module csp_deframe #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic              sld_s,
  output logic              sck_rise,
  output logic              sld_rise,
  output logic              commit_v,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  localparam int unsigned FRAME_W = ADDR_W + DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sck_q, sld_q;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      sld_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      sld_q <= sld_s;
    end
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sld_rise = sld_s & ~sld_q;

  // The strobe wins over a coincident shift edge; the count saturates one
  // past a full frame so that any longer transfer is also rejected.
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg       <= '0;
      bit_cnt     <= '0;
      commit_v    <= 1'b0;
      commit_addr <= '0;
      commit_data <= '0;
    end else begin
      commit_v <= 1'b0;
      if (sld_rise) begin
        bit_cnt <= '0;
        if (bit_cnt == CNT_FULL) begin
          commit_v    <= 1'b1;
          commit_addr <= shreg[FRAME_W-1 -: ADDR_W];
          commit_data <= shreg[DATA_W-1:0];
        end
      end else if (sck_rise) begin
        shreg <= {shreg[FRAME_W-2:0], sdi_s};
        if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csp_regbank.sv
`timescale 1ns/1ps
// Byte register bank: storage without reset (RAM-inferable) plus one
// written flag per entry that gives the zero-after-reset view.
module csp_regbank #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              update_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [DEPTH-1:0]  written;
  logic              rd_ok_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written  <= '0;
      rd_ok_q  <= 1'b0;
      update_o <= 1'b0;
    end else begin
      if (wr_en) written[wr_addr] <= 1'b1;
      rd_ok_q  <= written[rd_addr];
      update_o <= wr_en;
    end
  end

  assign rd_data = rd_ok_q ? rd_q : '0;
endmodule

// File: rtl/coef_serial_port.sv
`timescale 1ns/1ps
module coef_serial_port #(
  parameter int unsigned ADDR_W      = coef_serial_pkg::ADDR_BITS,
  parameter int unsigned DATA_W      = coef_serial_pkg::DATA_BITS,
  parameter int unsigned SYNC_STAGES = coef_serial_pkg::SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_ld_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              update_o
);
  logic [2:0]        pins_s;
  logic              sck_rise, sld_rise, commit_v;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;

  csp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst),
    .async_i({ser_ld_i, ser_dat_i, ser_clk_i}),
    .sync_o(pins_s)
  );

  csp_deframe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_deframe (
    .clk(clk), .rst(rst),
    .sck_s(pins_s[0]), .sdi_s(pins_s[1]), .sld_s(pins_s[2]),
    .sck_rise(sck_rise), .sld_rise(sld_rise),
    .commit_v(commit_v), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  csp_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bank (
    .clk(clk), .rst(rst),
    .wr_en(commit_v), .wr_addr(commit_addr), .wr_data(commit_data),
    .rd_addr(rd_addr_i), .rd_data(rd_data_o), .update_o(update_o)
  );
endmodule

// File: rtl/coef_serial_port_chk.sv
`timescale 1ns/1ps
module coef_serial_port_chk #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned DATA_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sck_rise,
  input logic              sld_rise,
  input logic              commit_v,
  input logic              update_o,
  input logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

  // Independent tally of synchronised shift edges since the last strobe.
  logic [CNT_W-1:0] edges_seen;
  always_ff @(posedge clk) begin
    if (rst) edges_seen <= '0;
    else if (sld_rise) edges_seen <= '0;
    else if (sck_rise && edges_seen != CNT_SAT) edges_seen <= edges_seen + 1'b1;
  end

  assert_reset_reads_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data_o == '0 && !update_o));

  assert_commit_full_frame_R4: assert property (@(posedge clk) disable iff (rst)
    commit_v |-> $past(edges_seen) == CNT_W'(FRAME_W));

  assert_update_follows_commit_R7: assert property (@(posedge clk) disable iff (rst)
    commit_v |=> update_o);

  assert_update_has_cause_R7: assert property (@(posedge clk) disable iff (rst)
    update_o |-> $past(commit_v));

  assert_update_single_R7: assert property (@(posedge clk) disable iff (rst)
    update_o |=> !update_o);
endmodule

bind coef_serial_port coef_serial_port_chk #(
  .FRAME_W(ADDR_W + DATA_W), .DATA_W(DATA_W)
) i_chk (
  .clk(clk), .rst(rst), .sck_rise(sck_rise), .sld_rise(sld_rise),
  .commit_v(commit_v), .update_o(update_o), .rd_data_o(rd_data_o)
);

// File: tb/test_coef_serial_port.sv
`timescale 1ns/1ps
module test_coef_serial_port;
  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       update;

  typedef struct packed { logic [7:0] a; logic [7:0] d; } item_t;
  item_t exp_q[$];
  logic [7:0] model [256];
  int n_vec = 0, n_bad = 0, pulses = 0, exp_pulses = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  coef_serial_port i_coef_serial_port (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_ld_i(ser_ld), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .update_o(update)
  );

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(logic [16:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic strobe();
    ser_ld = 1'b1;
    repeat (4) @(negedge clk);
    ser_ld = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic expect_write(logic [7:0] a, logic [7:0] d);
    exp_q.push_back('{a: a, d: d});
    model[a] = d;
    exp_pulses++;
  endtask

  task automatic write_frame(logic [7:0] a, logic [7:0] d);
    send_bits({1'b0, a, d}, 16);
    expect_write(a, d);
    strobe();
  endtask

  task automatic read_chk(string tag, logic [7:0] a);
    rd_addr = a;
    repeat (2) @(negedge clk);
    chk(tag, rd_data, model[a]);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Monitor: pops one expected write per update pulse and checks it.
  initial begin
    forever begin
      @(negedge clk);
      if (update) begin
        pulses++;
        if (exp_q.size() == 0) begin
          chk("R7 unexpected update pulse", 1, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          rd_addr = e.a;
          @(negedge clk);
          chk("R7 pulse one cycle wide", update, 0);
          @(negedge clk);
          chk("R3 committed data", rd_data, e.d);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 update low after reset", update, 0);
    read_chk("R1 reg 00 zero", 8'h00);
    read_chk("R8 reg 15 unwritten", 8'h15);
    read_chk("R1 reg FF zero", 8'hFF);

    write_frame(8'h15, 8'hA5);
    read_chk("R9 neighbour 16 untouched", 8'h16);
    write_frame(8'h16, 8'h3C);
    read_chk("R9 reg 15 kept", 8'h15);

    // Asymmetric frame shows bit order: reversed order would hit 01 with 80.
    write_frame(8'h80, 8'h01);
    read_chk("R2 reg 80", 8'h80);
    read_chk("R2 reg 01 untouched", 8'h01);

    send_bits(17'h07E77, 15);
    strobe();
    chk("R4 short frame no pulse", pulses, exp_pulses);
    read_chk("R4 short frame no write", 8'h0F);
    read_chk("R4 short frame no write alt", 8'h3B);

    strobe();
    chk("R4 bare strobe no pulse", pulses, exp_pulses);

    send_bits(17'h1C3AA, 17);
    strobe();
    chk("R5 long frame no pulse", pulses, exp_pulses);
    read_chk("R5 long frame no write", 8'hE1);
    read_chk("R5 long frame no write alt", 8'hC3);

    send_bits(17'h0002B, 5);
    strobe();
    write_frame(8'h42, 8'h99);
    chk("R6 recovery pulse", pulses, exp_pulses);
    read_chk("R6 recovered write", 8'h42);

    send_bits({1'b0, 8'h2C, 8'h6E}, 16);
    repeat (60) @(negedge clk);
    chk("R10 no pulse without strobe", pulses, exp_pulses);
    read_chk("R10 reg 2C unchanged", 8'h2C);
    expect_write(8'h2C, 8'h6E);
    strobe();
    chk("R10 held word committed pulse", pulses, exp_pulses);

    write_frame(8'h15, 8'h5A);
    read_chk("R9 overwrite", 8'h15);
    read_chk("R9 reg 16 kept", 8'h16);

    write_frame(8'hFF, 8'hFF);
    write_frame(8'h00, 8'h80);
    write_frame(8'hFE, 8'h00);
    read_chk("R3 reg FF", 8'hFF);
    read_chk("R3 reg 00", 8'h00);
    read_chk("R8 reg FE written zero", 8'hFE);

    chk("R7 total pulses", pulses, exp_pulses);
    chk("R7 queue drained", exp_q.size(), 0);
    finished = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end
endmodule